// File: doc/BRIEF.md
# Software-Driven Management Bus Port

This block is a small register slave on a 32-bit memory-mapped bus that lets a processor wiggle a two-wire management serial bus entirely in software. One control word holds the management clock level, a data bit and a drive-enable bit. A status word reports the present level of the bidirectional data line. Every time software writes a clock level that differs from the one currently held, the block raises a single-cycle edge strobe for the serial-bus decoder attached behind it.

The remaining word slots of the 92-byte window act as plain storage. They hold whatever was last written and have no other effect. Only aligned 32-bit accesses inside the window are accepted. Any other access raises a one-cycle error flag and leaves all state untouched.

Read data, the error flag, the strobe and the bus-side pins are all registered. Each of them changes on the clock edge that follows the access.

Top module: `mgmt_bitbang_regs`

## Requirements
- R1: After synchronous reset, `mgmt_clk` is 0, `mgmt_dout` is 1, `mgmt_oe` is 0, `clk_edge_stb` is 0, `bus_err` is 0, `bus_rdata` is 0, and every storage word reads 0.
- R2: On an accepted write to offset 0x28, `mgmt_clk` takes bit 2 of the write data on the next clock edge.
- R3: On an accepted write to offset 0x28, `mgmt_oe` takes bit 1. `mgmt_dout` takes bit 0 only when bit 1 of that same write is 1; otherwise `mgmt_dout` keeps its value.
- R4: `clk_edge_stb` is high for exactly one cycle after an accepted write to offset 0x28 whose bit 2 differs from the held clock level. It stays low after every other access.
- R5: A read of offset 0x2C returns the line level in bit 0 and zeros in bits 31:1. The line level is `mgmt_dout` when `mgmt_oe` is 1, and `mgmt_din` otherwise.
- R6: An access is legal only with `bus_size` = 2 (word). Size 0 (byte), 1 (halfword) or 3 sets `bus_err` for one cycle. The access then changes no state, and a read returns 0.
- R7: A read of offset 0x28 returns {29 zeros, clock, enable, data}, with the clock in bit 2, the enable in bit 1 and the data in bit 0.
- R8: Every other word-aligned offset below 0x5C reads back the last value written to it. Writes to offset 0x2C are discarded.
- R9: A misaligned address (bits 1:0 not zero) or an address at or above 0x5C sets `bus_err` exactly as R6 does, with no effect on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address within the window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle access error |
| mgmt_din | input | 1 | Level sensed on the data line |
| mgmt_dout | output | 1 | Value driven onto the data line |
| mgmt_oe | output | 1 | Data-line drive enable |
| mgmt_clk | output | 1 | Management clock level |
| clk_edge_stb | output | 1 | One-cycle strobe on each clock-level change |

## Verification
The bench repeats a control write with the same clock bit. A design that strobed on every write would pulse on that repeat, and one that compared against the new value would never pulse at all. It writes data with the enable bit clear and then with it set, and reads status with the drive on and off while the external line level changes. This exposes a design that lets bit 0 through unconditionally, or one that reports the driven bit while the line is released. Byte, halfword, misaligned and out-of-window writes aimed at the control word and at a storage word must leave both unchanged, and writes to the status slot must not become readable.

// File: rtl/mgmt_bb_pkg.sv
package mgmt_bb_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 7;
    localparam int WIN_BYTES = 92;
    localparam int NUM_WORDS = WIN_BYTES / 4;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int CTRL_OFF  = 'h28;
    localparam int STAT_OFF  = 'h2C;
    localparam int CTRL_IDX  = CTRL_OFF / 4;
    localparam int STAT_IDX  = STAT_OFF / 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_CTRL    = 2'd1,
        TGT_STAT    = 2'd2,
        TGT_STORE   = 2'd3
    } target_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        logic             err;
        target_e          tgt;
        logic [IDX_W-1:0] idx;
    } access_s;

    typedef struct packed {
        logic clk_lvl;
        logic drive_en;
        logic data_bit;
    } ctrl_s;

    function automatic ctrl_s ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_s c;
        c.clk_lvl  = w[2];
        c.drive_en = w[1];
        c.data_bit = w[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_s c);
        logic [DATA_W-1:0] w;
        w    = '0;
        w[2] = c.clk_lvl;
        w[1] = c.drive_en;
        w[0] = c.data_bit;
        return w;
    endfunction
endpackage

// File: rtl/mgmt_access_decode.sv
module mgmt_access_decode
    import mgmt_bb_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        size,
    output access_s           acc
);
    logic             in_window;
    logic             aligned;
    logic             word_sz;
    logic             legal;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_window = (int'(addr) < WIN_BYTES);
        aligned   = (addr[1:0] == 2'b00);
        word_sz   = (acc_size_e'(size) == SZ_WORD);
        legal     = in_window && aligned && word_sz;
        idx       = IDX_W'(addr[ADDR_W-1:2]);

        acc.idx = idx;
        acc.err = (wr || rd) && !legal;
        acc.wr  = wr && legal;
        acc.rd  = rd && legal;
        if (!legal)
            acc.tgt = TGT_NONE;
        else if (int'(idx) == CTRL_IDX)
            acc.tgt = TGT_CTRL;
        else if (int'(idx) == STAT_IDX)
            acc.tgt = TGT_STAT;
        else
            acc.tgt = TGT_STORE;
    end
endmodule

// File: rtl/mgmt_line_ctrl.sv
module mgmt_line_ctrl
    import mgmt_bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_s           acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              din,
    output logic              dout,
    output logic              oe,
    output logic              mclk,
    output logic              edge_stb,
    output logic              line_lvl,
    output logic [DATA_W-1:0] ctrl_word
);
    ctrl_s cur_q;
    ctrl_s wr_c;
    logic  wr_ctrl;
    logic  stb_q;

    always_comb begin
        wr_ctrl = acc.wr && (acc.tgt == TGT_CTRL);
        wr_c    = ctrl_from_word(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.clk_lvl  <= 1'b0;
            cur_q.drive_en <= 1'b0;
            cur_q.data_bit <= 1'b1;
            stb_q          <= 1'b0;
        end else begin
            stb_q <= wr_ctrl && (wr_c.clk_lvl != cur_q.clk_lvl);
            if (wr_ctrl) begin
                cur_q.clk_lvl  <= wr_c.clk_lvl;
                cur_q.drive_en <= wr_c.drive_en;
                if (wr_c.drive_en)
                    cur_q.data_bit <= wr_c.data_bit;
            end
        end
    end

    always_comb begin
        dout      = cur_q.data_bit;
        oe        = cur_q.drive_en;
        mclk      = cur_q.clk_lvl;
        edge_stb  = stb_q;
        line_lvl  = cur_q.drive_en ? cur_q.data_bit : din;
        ctrl_word = ctrl_to_word(cur_q);
    end

    // R4
    edge_follows_change_chk: assert property (@(posedge clk) disable iff (rst)
        edge_stb |-> (mclk != $past(mclk)));

    // R3
    dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_ctrl) |-> $stable(dout));

    // R2
    clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_ctrl) |-> ($stable(mclk) && !edge_stb));
endmodule

// File: rtl/mgmt_store_bank.sv
module mgmt_store_bank
    import mgmt_bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  access_s           acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    logic [NUM_WORDS*DATA_W-1:0] words_flat;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        if (g == CTRL_IDX || g == STAT_IDX) begin : g_hole
            assign words_flat[g*DATA_W +: DATA_W] = '0;
        end else begin : g_cell
            logic [DATA_W-1:0] cell_q;
            always_ff @(posedge clk) begin
                if (rst)
                    cell_q <= '0;
                else if (acc.wr && acc.tgt == TGT_STORE && int'(acc.idx) == g)
                    cell_q <= wdata;
            end
            assign words_flat[g*DATA_W +: DATA_W] = cell_q;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++)
            if (int'(acc.idx) == i)
                rd_word = words_flat[i*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/mgmt_bitbang_regs.sv
module mgmt_bitbang_regs
    import mgmt_bb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              mgmt_din,
    output logic              mgmt_dout,
    output logic              mgmt_oe,
    output logic              mgmt_clk,
    output logic              clk_edge_stb
);
    access_s           acc;
    logic              line_lvl;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] store_word;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    mgmt_access_decode u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .size (bus_size),
        .acc  (acc)
    );

    mgmt_line_ctrl u_line (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .wdata     (bus_wdata),
        .din       (mgmt_din),
        .dout      (mgmt_dout),
        .oe        (mgmt_oe),
        .mclk      (mgmt_clk),
        .edge_stb  (clk_edge_stb),
        .line_lvl  (line_lvl),
        .ctrl_word (ctrl_word)
    );

    mgmt_store_bank u_store (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .wdata   (bus_wdata),
        .rd_word (store_word)
    );

    always_comb begin
        unique case (acc.tgt)
            TGT_CTRL:  rd_mux = ctrl_word;
            TGT_STAT:  rd_mux = {{(DATA_W-1){1'b0}}, line_lvl};
            TGT_STORE: rd_mux = store_word;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= acc.err;
            if (acc.rd)
                rdata_q <= rd_mux;
            else if (acc.err && bus_rd)
                rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;

    // R6
    err_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($stable(mgmt_clk) && $stable(mgmt_oe) && $stable(mgmt_dout) && !clk_edge_stb));

    // R5
    stat_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(acc.rd) && $past(acc.tgt) == TGT_STAT) |-> (bus_rdata[DATA_W-1:1] == '0));

    // R9
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> $past(bus_wr || bus_rd));
endmodule

// File: tb/mgmt_bitbang_regs_test.sv
module mgmt_bitbang_regs_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic        mgmt_din = 1'b1;
    logic        mgmt_dout, mgmt_oe, mgmt_clk, clk_edge_stb;

    always #4 clk = ~clk;

    mgmt_bitbang_regs uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .mgmt_din(mgmt_din), .mgmt_dout(mgmt_dout), .mgmt_oe(mgmt_oe),
        .mgmt_clk(mgmt_clk), .clk_edge_stb(clk_edge_stb)
    );

    typedef struct {
        int          sig;
        logic [31:0] exp;
        int          due;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          cyc = 0;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic        m_clk, m_oe, m_dout;
    logic [31:0] m_mem [23];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] observe(input int s);
        case (s)
            0: return bus_rdata;
            1: return {31'b0, bus_err};
            2: return {31'b0, clk_edge_stb};
            3: return {31'b0, mgmt_clk};
            4: return {31'b0, mgmt_dout};
            default: return {31'b0, mgmt_oe};
        endcase
    endfunction

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            logic [31:0] got;
            it  = sb.pop_front();
            got = observe(it.sig);
            n_cmp++;
            if (got !== it.exp) begin
                n_bad++;
                $display("FAIL %s sig%0d: got %h expected %h", it.tag, it.sig, got, it.exp);
            end
        end
    end

    task automatic push(input int s, input logic [31:0] e, input string tag);
        item_t it;
        it.sig = s; it.exp = e; it.due = cyc + 1; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic push_pins(input string tag);
        push(3, {31'b0, m_clk}, tag);
        push(4, {31'b0, m_dout}, tag);
        push(5, {31'b0, m_oe}, tag);
    endtask

    task automatic access(input bit w, input logic [6:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input string tag);
        bit   legal;
        logic stb;
        logic [31:0] rexp;
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = w; bus_rd = !w;
        legal = (sz == 2'd2) && (a[1:0] == 2'b00) && (a < 7'd92);
        stb = 1'b0;
        rexp = '0;
        if (legal && w) begin
            if (a == 7'h28) begin
                stb = (d[2] != m_clk);
                m_clk = d[2];
                m_oe = d[1];
                if (d[1]) m_dout = d[0];
            end else if (a != 7'h2C) begin
                m_mem[a >> 2] = d;
            end
        end else if (legal) begin
            if (a == 7'h28)      rexp = {29'b0, m_clk, m_oe, m_dout};
            else if (a == 7'h2C) rexp = {31'b0, m_oe ? m_dout : mgmt_din};
            else                 rexp = m_mem[a >> 2];
        end
        push(1, {31'b0, !legal}, tag);
        push(2, {31'b0, stb}, tag);
        push_pins(tag);
        if (!w) push(0, rexp, tag);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    initial begin
        m_clk = 1'b0; m_oe = 1'b0; m_dout = 1'b1;
        for (int i = 0; i < 23; i++) m_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        push(0, 32'h0, "R1"); push(1, 32'h0, "R1"); push(2, 32'h0, "R1");
        push_pins("R1");
        @(negedge clk);
        access(1'b0, 7'h00, 2'd2, 0, "R1 store reset");
        access(1'b0, 7'h28, 2'd2, 0, "R7 ctrl reset");
        // R2 / R4 clock toggles
        access(1'b1, 7'h28, 2'd2, 32'h4, "R2 R4 clk rise");
        access(1'b1, 7'h28, 2'd2, 32'h4, "R4 clk same no strobe");
        access(1'b1, 7'h28, 2'd2, 32'h0, "R4 clk fall");
        access(1'b1, 7'h28, 2'd2, 32'h4, "R4 back to back rise");
        // R3 data gated by enable
        access(1'b1, 7'h28, 2'd2, 32'h4, "R3 data0 no enable");
        access(1'b1, 7'h28, 2'd2, 32'h6, "R3 data0 enabled");
        access(1'b1, 7'h28, 2'd2, 32'h5, "R3 data1 enable off");
        access(1'b1, 7'h28, 2'd2, 32'h3, "R3 data1 enabled");
        access(1'b0, 7'h28, 2'd2, 0, "R7 ctrl readback");
        // R5 status level
        mgmt_din = 1'b0;
        access(1'b0, 7'h2C, 2'd2, 0, "R5 status driven");
        access(1'b1, 7'h28, 2'd2, 32'h0, "R5 release line");
        access(1'b0, 7'h2C, 2'd2, 0, "R5 status external low");
        mgmt_din = 1'b1;
        access(1'b0, 7'h2C, 2'd2, 0, "R5 status external high");
        // R8 storage
        access(1'b1, 7'h00, 2'd2, 32'hDEADBEEF, "R8 store w0");
        access(1'b1, 7'h58, 2'd2, 32'h12345678, "R8 store last");
        access(1'b0, 7'h00, 2'd2, 0, "R8 read w0");
        access(1'b0, 7'h58, 2'd2, 0, "R8 read last");
        access(1'b1, 7'h2C, 2'd2, 32'hFFFFFFFF, "R8 status write dropped");
        access(1'b0, 7'h2C, 2'd2, 0, "R8 status after write");
        // R6 size errors
        access(1'b1, 7'h28, 2'd0, 32'h7, "R6 byte ctrl write");
        access(1'b1, 7'h28, 2'd1, 32'h7, "R6 half ctrl write");
        access(1'b1, 7'h00, 2'd3, 32'h1, "R6 rsvd store write");
        access(1'b0, 7'h00, 2'd0, 0, "R6 byte read");
        access(1'b0, 7'h00, 2'd2, 0, "R6 store intact");
        access(1'b0, 7'h28, 2'd2, 0, "R6 ctrl intact");
        // R9 address errors
        access(1'b1, 7'h29, 2'd2, 32'h7, "R9 misaligned ctrl");
        access(1'b1, 7'h5C, 2'd2, 32'h7, "R9 out of window");
        access(1'b0, 7'h7C, 2'd2, 0, "R9 read out of window");
        access(1'b0, 7'h28, 2'd2, 0, "R9 ctrl intact");
        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d left, expected 0", sb.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule